// File: doc/BRIEF.md
# Transmit Checksum Insertion Engine

This block sits in a transmit path ahead of the MAC. For every outgoing frame it first takes a five-word sideband header and then the frame bytes. If the header asks for checksum offload, the engine adds up the frame as 16-bit big-endian words. The sum starts at a byte offset the header gives and runs to the last byte. The engine then adds a 16-bit seed from the header, folds the carries and inverts the result. It writes the 16-bit value back into the frame at a second offset from the header, high byte first.

The insertion point can lie before the end of the summed range, so the frame is held in an internal store-and-forward buffer. Output starts only after the last input byte has been accepted and the patch is done. The engine also applies two drop rules. When transmit is disabled, frames are consumed and thrown away. When both jumbo and VLAN support are off, frames of 1519 to 1522 bytes are discarded. After each forwarded frame the engine pulses a completion flag.

Top module: `tx_csum_insert`

## Requirements
- R1: After reset the engine is waiting for a header: `hdr_ready_o`=1, `in_ready_o`=0, `out_valid_o`=0, `tx_done_o`=0. It accepts exactly five 32-bit header words, and frame bytes are accepted only after the fifth word.
- R2: Bit 0 of header word 0 enables offload. When it is 0 the frame is forwarded byte for byte unchanged. All other bits of word 0, words 3 and 4, and bits 31:16 of word 2 have no effect.
- R3: Header word 1 bits 31:16 give the start offset S. Every byte at index i ≥ S (index 0 is the first byte) is summed. Bytes with (i−S) even are taken as the high byte of a 16-bit word and the rest as the low byte, so an odd trailing byte is padded with a zero low byte. If S is at or beyond the frame length, nothing is summed.
- R4: Header word 2 bits 15:0 are added to the sum as a seed. Carries out of bit 15 are folded back until the value fits in 16 bits, and the result is the one's complement of that value.
- R5: Header word 1 bits 15:0 give the insertion offset P. The result's high byte replaces byte P and its low byte replaces byte P+1. A position at or beyond the frame length is left unwritten. The sum uses the frame bytes as received.
- R6: No output byte appears before the last input byte has been accepted. Output bytes come in input order, and `out_last_o` is set on the final byte only.
- R7: If `tx_en_i` is 0 in the cycle after the last input byte, the frame is discarded: no output and no completion pulse.
- R8: If `jumbo_en_i` and `vlan_en_i` are both 0, a frame of 1519 to 1522 bytes is discarded. Lengths of 1518 and 1523 are forwarded, and with either enable set a 1520-byte frame is forwarded.
- R9: `tx_done_o` is a one-cycle pulse in the cycle after the handshake of the final output byte. The engine is then ready for the next header.
- R10: Bytes beyond the buffer depth are accepted but dropped. A longer frame goes out as its first DEPTH bytes, with `out_last_o` on byte DEPTH−1.
- R11: While `out_valid_o` is 1 and `out_ready_i` is 0, the output byte and `out_last_o` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable; frames are discarded when 0 |
| jumbo_en_i | input | 1 | Jumbo frame enable |
| vlan_en_i | input | 1 | VLAN tagged frame enable |
| hdr_valid_i | input | 1 | Header word valid |
| hdr_data_i | input | 32 | Header word |
| hdr_ready_o | output | 1 | Header word accepted |
| in_valid_i | input | 1 | Frame byte valid |
| in_data_i | input | 8 | Frame byte |
| in_last_i | input | 1 | Final byte of the frame |
| in_ready_o | output | 1 | Frame byte accepted |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_last_o | output | 1 | Final output byte |
| out_ready_i | input | 1 | Downstream accepts the output byte |
| tx_done_o | output | 1 | Pulse after each forwarded frame |

## Verification
The bench builds the engine with its default depth of 2048 bytes. At that depth it can send frames at exactly 1518, 1519, 1522 and 1523 bytes to probe the length drop rule. It can also send a 2050-byte frame, which reaches the truncation boundary. Around these cases it runs random frames with random start and insertion offsets, seeds and output backpressure. Directed cases cover an odd trailing byte, a start offset past the end and an insertion offset at the last byte.

// File: rtl/tx_csum_pkg.sv
package tx_csum_pkg;
  localparam int HDR_WORDS = 5;
  localparam int ACC_W     = 32;

  typedef enum logic [2:0] {
    ST_HDR, ST_RECV, ST_CHK, ST_PATCH_HI, ST_PATCH_LO, ST_SEND
  } state_e;

  typedef struct packed {
    logic        offload;
    logic [15:0] start;
    logic [15:0] ins;
    logic [15:0] seed;
  } hdr_t;

  // add seed, fold end-around carries, invert
  function automatic logic [15:0] csum_fold(input logic [ACC_W-1:0] acc,
                                            input logic [15:0] seed);
    logic [32:0] t;
    logic [16:0] f1, f2, f3;
    t  = {1'b0, acc} + 33'(seed);
    f1 = 17'(t[15:0]) + 17'(t[31:16]) + 17'(t[32]);
    f2 = 17'(f1[15:0]) + 17'(f1[16]);
    f3 = 17'(f2[15:0]) + 17'(f2[16]);
    return ~f3[15:0];
  endfunction
endpackage

// File: rtl/tx_csum_hdr.sv
module tx_csum_hdr
  import tx_csum_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic [31:0] word_i,
  output hdr_t        hdr_o,
  output logic        last_o
);
  logic [2:0] idx_q;
  logic       unused_hdr_bits;

  assign last_o          = (idx_q == 3'(HDR_WORDS - 1));
  assign unused_hdr_bits = ^word_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      hdr_o <= '0;
    end else if (load_i) begin
      idx_q <= last_o ? 3'd0 : idx_q + 3'd1;
      case (idx_q)
        3'd0: hdr_o.offload <= word_i[0];
        3'd1: begin
          hdr_o.start <= word_i[31:16];
          hdr_o.ins   <= word_i[15:0];
        end
        3'd2: hdr_o.seed <= word_i[15:0];
        default: ;
      endcase
    end
  end

  assert_idx_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q < 3'(HDR_WORDS));
  assert_idx_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && last_o) |=> (idx_q == 3'd0));
endmodule

// File: rtl/tx_csum_acc.sv
module tx_csum_acc
  import tx_csum_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        add_i,
  input  logic [15:0] pos_i,
  input  logic [7:0]  byte_i,
  input  logic [15:0] start_i,
  input  logic [15:0] seed_i,
  output logic [15:0] csum_o
);
  logic [ACC_W-1:0] acc_q, term;
  logic             in_range, hi_lane;

  assign in_range = (pos_i >= start_i);
  assign hi_lane  = ~(pos_i[0] ^ start_i[0]);
  assign term     = hi_lane ? ACC_W'({byte_i, 8'h00}) : ACC_W'(byte_i);
  assign csum_o   = csum_fold(acc_q, seed_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                acc_q <= '0;
    else if (clr_i)             acc_q <= '0;
    else if (add_i && in_range) acc_q <= acc_q + term;
  end

  assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_q == '0));
  assert_skip_below_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !(add_i && in_range)) |=> $stable(acc_q));
endmodule

// File: rtl/tx_csum_buf.sv
module tx_csum_buf #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tx_csum_insert.sv
module tx_csum_insert
  import tx_csum_pkg::*;
#(
  parameter int DEPTH     = 2048,
  parameter int MAX_STD   = 1518,
  parameter int TAG_BYTES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tx_en_i,
  input  logic        jumbo_en_i,
  input  logic        vlan_en_i,
  input  logic        hdr_valid_i,
  input  logic [31:0] hdr_data_i,
  output logic        hdr_ready_o,
  input  logic        in_valid_i,
  input  logic [7:0]  in_data_i,
  input  logic        in_last_i,
  output logic        in_ready_o,
  output logic        out_valid_o,
  output logic [7:0]  out_data_o,
  output logic        out_last_o,
  input  logic        out_ready_i,
  output logic        tx_done_o
);
  state_e        state_q;
  logic [LW-1:0] len_q;
  logic [AW-1:0] rd_ptr_q;
  logic          done_q;

  hdr_t          hdr;
  logic          hdr_load, hdr_last;
  logic          in_hs, out_hs, store_en, drop;
  logic [15:0]   csum;
  logic          hit_hi, hit_lo;
  logic          buf_we;
  logic [AW-1:0] buf_waddr;
  logic [7:0]    buf_wdata;

  assign hdr_ready_o = (state_q == ST_HDR);
  assign in_ready_o  = (state_q == ST_RECV);
  assign out_valid_o = (state_q == ST_SEND);
  assign out_last_o  = out_valid_o && (LW'(rd_ptr_q) == len_q - LW'(1));
  assign tx_done_o   = done_q;

  assign hdr_load = hdr_valid_i && hdr_ready_o;
  assign in_hs    = in_valid_i && in_ready_o;
  assign out_hs   = out_valid_o && out_ready_i;
  assign store_en = in_hs && (len_q < LW'(DEPTH));

  // oversize-but-tagged window is dropped unless jumbo or vlan allowed
  assign drop = !tx_en_i ||
                (!jumbo_en_i && !vlan_en_i &&
                 (32'(len_q) > MAX_STD) && (32'(len_q) <= MAX_STD + TAG_BYTES));

  assign hit_hi = ({1'b0, hdr.ins} < 17'(len_q));
  assign hit_lo = ({1'b0, hdr.ins} + 17'd1 < 17'(len_q));

  tx_csum_hdr u_hdr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (hdr_load),
    .word_i (hdr_data_i),
    .hdr_o  (hdr),
    .last_o (hdr_last)
  );

  tx_csum_acc u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (hdr_load && hdr_last),
    .add_i   (store_en),
    .pos_i   (16'(len_q)),
    .byte_i  (in_data_i),
    .start_i (hdr.start),
    .seed_i  (hdr.seed),
    .csum_o  (csum)
  );

  always_comb begin
    buf_we    = 1'b0;
    buf_waddr = len_q[AW-1:0];
    buf_wdata = in_data_i;
    unique case (state_q)
      ST_RECV: buf_we = store_en;
      ST_PATCH_HI: begin
        buf_we    = hit_hi;
        buf_waddr = hdr.ins[AW-1:0];
        buf_wdata = csum[15:8];
      end
      ST_PATCH_LO: begin
        buf_we    = hit_lo;
        buf_waddr = hdr.ins[AW-1:0] + AW'(1);
        buf_wdata = csum[7:0];
      end
      default: ;
    endcase
  end

  tx_csum_buf #(.DEPTH(DEPTH)) u_buf (
    .clk_i   (clk_i),
    .we_i    (buf_we),
    .waddr_i (buf_waddr),
    .wdata_i (buf_wdata),
    .raddr_i (rd_ptr_q),
    .rdata_o (out_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_HDR;
      len_q    <= '0;
      rd_ptr_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_HDR: if (hdr_load && hdr_last) begin
          state_q <= ST_RECV;
          len_q   <= '0;
        end
        ST_RECV: if (in_hs) begin
          if (store_en) len_q <= len_q + LW'(1);
          if (in_last_i) state_q <= ST_CHK;
        end
        ST_CHK: begin
          rd_ptr_q <= '0;
          if (drop)             state_q <= ST_HDR;
          else if (hdr.offload) state_q <= ST_PATCH_HI;
          else                  state_q <= ST_SEND;
        end
        ST_PATCH_HI: state_q <= ST_PATCH_LO;
        ST_PATCH_LO: state_q <= ST_SEND;
        ST_SEND: if (out_hs) begin
          if (out_last_o) begin
            state_q <= ST_HDR;
            done_q  <= 1'b1;
          end else begin
            rd_ptr_q <= rd_ptr_q + AW'(1);
          end
        end
        default: state_q <= ST_HDR;
      endcase
    end
  end

  assert_hdr_excl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_ready_o |-> (!in_ready_o && !out_valid_o));
  assert_no_early_out_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> !out_valid_o);
  assert_len_cap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_q <= LW'(DEPTH));
  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |-> $past(out_valid_o && out_ready_i && out_last_o));
  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |=> !tx_done_o);
endmodule

// File: tb/tx_csum_insert_tb.sv
module tx_csum_insert_tb;
  localparam int DEPTH = 2048;
  localparam int MAXF  = 2100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_en = 1'b1, jumbo_en = 1'b0, vlan_en = 1'b0;
  logic        hdr_valid = 1'b0;
  logic [31:0] hdr_data = '0;
  logic        hdr_ready;
  logic        in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic [7:0]  in_data = '0;
  logic        out_valid, out_last, out_ready = 1'b0, tx_done;
  logic [7:0]  out_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] fr  [MAXF];
  logic [7:0] exp_b [MAXF];

  always #4 clk = ~clk;

  tx_csum_insert u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .jumbo_en_i(jumbo_en),
    .vlan_en_i(vlan_en), .hdr_valid_i(hdr_valid), .hdr_data_i(hdr_data),
    .hdr_ready_o(hdr_ready), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_last_i(in_last), .in_ready_o(in_ready), .out_valid_o(out_valid),
    .out_data_o(out_data), .out_last_o(out_last), .out_ready_i(out_ready),
    .tx_done_o(tx_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] model_csum(input int len, input int start,
                                             input int seed);
    longint s = 0;
    for (int i = start; i < len; i++)
      s += ((i - start) % 2 == 0) ? (longint'(fr[i]) << 8) : longint'(fr[i]);
    s += seed;
    while (s > 64'hFFFF) s = (s & 64'hFFFF) + (s >> 16);
    return ~s[15:0];
  endfunction

  task automatic send_word(input logic [31:0] w);
    hdr_valid = 1'b1;
    hdr_data  = w;
    while (!hdr_ready) @(negedge clk);
    @(negedge clk);
    hdr_valid = 1'b0;
  endtask

  task automatic run_frame(input bit off, input int start, input int ins,
                           input int seed, input int len, input bit txen,
                           input bit jum, input bit vl, input string req);
    int elen, cnt, tmo, bad, first_bad;
    bit drop, early, seen_last;
    logic [15:0] c;
    tx_en = txen; jumbo_en = jum; vlan_en = vl;
    for (int i = 0; i < len; i++) fr[i] = 8'($urandom);
    // undefined header bits are randomized: they must not matter (R2)
    send_word({$urandom, 1'b0} | 32'(off));
    chk(!in_ready, "R1", "in_ready before header done", in_ready, 0);
    send_word({16'(start), 16'(ins)});
    send_word({16'($urandom), 16'(seed)});
    send_word($urandom);
    send_word($urandom);
    early = 1'b0;
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1; in_data = fr[i]; in_last = (i == len - 1);
      while (!in_ready) @(negedge clk);
      if (out_valid) early = 1'b1;
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
    chk(!early, "R6", "output during input", early, 0);

    elen = (len < DEPTH) ? len : DEPTH;
    drop = !txen || (!jum && !vl && elen >= 1519 && elen <= 1522);
    for (int i = 0; i < elen; i++) exp_b[i] = fr[i];
    if (off) begin
      c = model_csum(elen, start, seed);
      if (ins < elen)     exp_b[ins]     = c[15:8];
      if (ins + 1 < elen) exp_b[ins + 1] = c[7:0];
    end

    if (drop) begin
      bad = 0;
      repeat (8) begin
        if (out_valid || tx_done) bad++;
        @(negedge clk);
      end
      chk(bad == 0, req, "dropped frame produced output", bad, 0);
      chk(hdr_ready, req, "ready for header after drop", hdr_ready, 1);
      return;
    end

    cnt = 0; tmo = 0; bad = 0; first_bad = -1; seen_last = 1'b0;
    while (!seen_last && tmo < 20000) begin
      out_ready = ($urandom % 4) != 0;
      #1;
      if (out_valid && out_ready) begin
        if (cnt < MAXF && out_data !== exp_b[cnt]) begin
          bad++;
          if (first_bad < 0) first_bad = cnt;
        end
        if (out_last) seen_last = 1'b1;
        else if (tx_done) bad++;
        cnt++;
      end
      tmo++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(cnt == elen, req, "output byte count", cnt, elen);
    if (first_bad >= 0)
      chk(1'b0, req, "output byte mismatch at index", first_bad, -1);
    else
      chk(bad == 0, req, "output bytes", bad, 0);
    chk(tx_done == 1'b1, "R9", "tx_done after last byte", tx_done, 1);
    @(negedge clk);
    chk(tx_done == 1'b0, "R9", "tx_done single cycle", tx_done, 0);
    chk(hdr_ready, "R9", "ready for next header", hdr_ready, 1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hdr_ready == 1'b1, "R1", "reset hdr_ready", hdr_ready, 1);
    chk(in_ready == 1'b0, "R1", "reset in_ready", in_ready, 0);
    chk(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
    chk(tx_done == 1'b0, "R1", "reset tx_done", tx_done, 0);

    run_frame(0, 14, 24, 16'h5a5a, 60, 1, 0, 0, "R2");
    run_frame(1, 14, 24, 16'h0000, 61, 1, 0, 0, "R3");
    run_frame(1, 13, 4, 16'h1234, 40, 1, 0, 0, "R3");
    run_frame(1, 100, 2, 16'h1234, 60, 1, 0, 0, "R3");
    for (int i = 0; i < 64; i++) fr[i] = 8'hff;
    run_frame(1, 0, 10, 16'hffff, 64, 1, 0, 0, "R4");
    run_frame(1, 0, 59, 16'h0abc, 60, 1, 0, 0, "R5");
    run_frame(1, 0, 60, 16'h0abc, 60, 1, 0, 0, "R5");
    run_frame(1, 20, 0, 16'h0001, 50, 1, 0, 0, "R5");
    run_frame(1, 14, 24, 16'h0000, 80, 0, 0, 0, "R7");
    run_frame(0, 0, 0, 0, 1518, 1, 0, 0, "R8");
    run_frame(0, 0, 0, 0, 1519, 1, 0, 0, "R8");
    run_frame(1, 14, 30, 0, 1522, 1, 0, 0, "R8");
    run_frame(1, 14, 30, 0, 1523, 1, 0, 0, "R8");
    run_frame(1, 14, 30, 0, 1520, 1, 1, 0, "R8");
    run_frame(1, 14, 30, 0, 1520, 1, 0, 1, "R8");
    run_frame(1, 14, 2046, 16'h7777, 2050, 1, 0, 0, "R10");

    for (int n = 0; n < 30; n++) begin
      int len = 20 + int'($urandom % 200);
      run_frame(1'($urandom), int'($urandom % (len + 4)),
                int'($urandom % (len + 2)), int'($urandom % 65536),
                len, 1, 0, 0, "R11");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule